// File: doc/BRIEF.md
# Configurable Watchdog Timer Controller

This block is a watchdog timer that software sets up through a single 8-bit mode register. The register can be written but not read back. The timer counts timebase ticks from one of two sources: an on-chip RC tick or a crystal tick. Either tick arrives as a slow, asynchronous level. The block brings it into the system-clock domain through a two-flop synchronizer and then takes its rising edge.

When the count reaches the timeout tap chosen by the mode register, the block drives a reset request for one system clock. It then starts counting again from zero. Software keeps the timer from expiring by pulsing a refresh strobe.

Two mode bits decide whether counting goes on while the core reports HALT or STOP. With a bit cleared, the count holds its value for as long as that state lasts. Any write to the mode register also clears the count.

Top module: `wdog_ctrl`

## Requirements
- R1: After reset, `wdt_rst` is low and the mode is tap code 01, counting enabled in HALT, counting enabled in STOP, RC source. The first timeout therefore follows 10×`RC_MS_TICKS` RC ticks.
- R2: With mode bit 4 = 0 (RC source), tap codes 00, 01, 10 and 11 in bits 1:0 time out on the 5th, 10th, 20th and 80th millisecond of RC ticks. One millisecond is `RC_MS_TICKS` ticks.
- R3: With mode bit 4 = 1 (crystal source), tap codes 00, 01, 10 and 11 time out on the 128th, 256th, 512th and 2048th crystal tick.
- R4: A timeout produces a `wdt_rst` pulse exactly one cycle wide. The count restarts from zero, so the next timeout needs a further full tap of ticks. No pulse appears before the tap is reached.
- R5: The pulse is visible in the third cycle after the cycle in which the tick input rises (two synchronizer flops plus the counter register). A tick held high for several cycles counts once.
- R6: With mode bit 2 = 0, ticks arriving while `halt` is high are not counted and the count is kept. With bit 2 = 1, counting goes on during HALT.
- R7: With mode bit 3 = 0, ticks arriving while `stop` is high are not counted and the count is kept. With bit 3 = 1, counting goes on during STOP.
- R8: A `refresh` pulse clears the count to zero, so a full tap of further ticks is needed for a timeout.
- R9: A write to the mode register clears the count to zero.
- R10: Mode bits 7:5 are reserved. Their written value has no effect on timing.
- R11: Ticks on the source that is not selected are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_tick | input | 1 | Asynchronous RC timebase tick level |
| xt_tick | input | 1 | Asynchronous crystal timebase tick level |
| halt | input | 1 | Core is in HALT |
| stop | input | 1 | Core is in STOP |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| refresh | input | 1 | Software refresh strobe, clears the count |
| wdt_rst | output | 1 | One-cycle reset request on timeout |

## Verification
The only observable output is the reset pulse, so a wrong count, tap, limit or freeze decision can only show up as a timeout that comes early, comes late or never comes. The scoreboard therefore predicts the exact cycle of every pulse from the tick sequence it drives. For each tap it checks that no pulse has appeared one tick before the tap and that the pulse lands exactly three cycles after the final tick. A count that leaks across a refresh, a mode write, a frozen HALT or STOP interval, or ticks on the unselected source shifts the next pulse by at least one tick period. That error is therefore caught at the very next expected timeout.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Field order matches write-data bits 4..0
  typedef struct packed {
    logic       src_xt;    // bit 4: 0 = RC tick, 1 = crystal tick
    logic       stop_run;  // bit 3: keep counting during STOP
    logic       halt_run;  // bit 2: keep counting during HALT
    logic [1:0] tap;       // bits 1:0: timeout tap code
  } wdog_mode_t;

  localparam int MODE_W   = $bits(wdog_mode_t);
  localparam int CFG_W    = 8;
  localparam int NUM_TAPS = 4;
  localparam int NUM_SRC  = 2;
  localparam int SRC_RC   = 0;
  localparam int SRC_XT   = 1;

  localparam wdog_mode_t MODE_RESET = '{src_xt: 1'b0, stop_run: 1'b1,
                                        halt_run: 1'b1, tap: 2'b01};

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic tick_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], tick_async};
      last_q <= chain[STAGES-1];
    end
  end

  assign tick_rise = chain[STAGES-1] & ~last_q;

  // R5: one rising edge yields a single-cycle event
  assert_single_edge_R5: assert property (@(posedge clk) disable iff (rst)
    tick_rise |=> !tick_rise);

endmodule

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output wdog_mode_t       mode
);
  always_ff @(posedge clk) begin
    if (rst)         mode <= MODE_RESET;
    else if (cfg_we) mode <= wdog_mode_t'(cfg_wdata[MODE_W-1:0]);
  end

  // R10: reserved upper bits never reach the stored mode
  assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> mode == $past(cfg_wdata[MODE_W-1:0]));

  // R1: mode is unchanged without a write
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(mode));

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int          CNT_W = 12,
  parameter int unsigned RC_LIM [NUM_TAPS] = '{5, 10, 20, 80},
  parameter int unsigned XT_LIM [NUM_TAPS] = '{128, 256, 512, 2048}
) (
  input  logic       clk,
  input  logic       rst,
  input  wdog_mode_t mode,
  input  logic       rc_rise,
  input  logic       xt_rise,
  input  logic       halt,
  input  logic       stop,
  input  logic       refresh,
  input  logic       cfg_we,
  output logic       wdt_pulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             tick_sel;
  logic             run_ok;

  always_comb begin
    limit    = mode.src_xt ? CNT_W'(XT_LIM[mode.tap]) : CNT_W'(RC_LIM[mode.tap]);
    tick_sel = mode.src_xt ? xt_rise : rc_rise;
    run_ok   = !(halt && !mode.halt_run) && !(stop && !mode.stop_run);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      wdt_pulse <= 1'b0;
    end else begin
      wdt_pulse <= 1'b0;
      if (cfg_we || refresh) begin
        cnt <= '0;
      end else if (tick_sel && run_ok) begin
        if (cnt == limit - 1'b1) begin
          cnt       <= '0;
          wdt_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: count stays below the active tap
  assert_below_tap_R4: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);

  // R4: reset request is one cycle wide
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    wdt_pulse |=> !wdt_pulse);

  // R6: frozen during HALT when bit 2 is clear
  assert_freeze_halt_R6: assert property (@(posedge clk) disable iff (rst)
    (halt && !mode.halt_run && !cfg_we && !refresh) |=> $stable(cnt));

  // R7: frozen during STOP when bit 3 is clear
  assert_freeze_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (stop && !mode.stop_run && !cfg_we && !refresh) |=> $stable(cnt));

  // R8: refresh clears and suppresses a timeout
  assert_refresh_clears_R8: assert property (@(posedge clk) disable iff (rst)
    refresh |=> (cnt == '0 && !wdt_pulse));

  // R9: mode write clears the count
  assert_write_clears_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cnt == '0 && !wdt_pulse));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned RC_MS_TICKS = 1,
  parameter int unsigned RC_MS0 = 5,
  parameter int unsigned RC_MS1 = 10,
  parameter int unsigned RC_MS2 = 20,
  parameter int unsigned RC_MS3 = 80,
  parameter int unsigned XT_TAP0 = 128,
  parameter int unsigned XT_TAP1 = 256,
  parameter int unsigned XT_TAP2 = 512,
  parameter int unsigned XT_TAP3 = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rc_tick,
  input  logic             xt_tick,
  input  logic             halt,
  input  logic             stop,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             refresh,
  output logic             wdt_rst
);
  localparam int unsigned RC_LIM [NUM_TAPS] = '{RC_MS0 * RC_MS_TICKS, RC_MS1 * RC_MS_TICKS,
                                                RC_MS2 * RC_MS_TICKS, RC_MS3 * RC_MS_TICKS};
  localparam int unsigned XT_LIM [NUM_TAPS] = '{XT_TAP0, XT_TAP1, XT_TAP2, XT_TAP3};

  function automatic int unsigned max_lim();
    int unsigned m = 1;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (RC_LIM[i] > m) m = RC_LIM[i];
      if (XT_LIM[i] > m) m = XT_LIM[i];
    end
    return m;
  endfunction

  localparam int CNT_W = $clog2(max_lim() + 1);

  logic [NUM_SRC-1:0] raw_tick;
  logic [NUM_SRC-1:0] tick_rise;
  wdog_mode_t         mode;

  assign raw_tick[SRC_RC] = rc_tick;
  assign raw_tick[SRC_XT] = xt_tick;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst        (rst),
      .tick_async (raw_tick[g]),
      .tick_rise  (tick_rise[g])
    );
  end

  wdog_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .mode      (mode)
  );

  wdog_count #(
    .CNT_W  (CNT_W),
    .RC_LIM (RC_LIM),
    .XT_LIM (XT_LIM)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .rc_rise   (tick_rise[SRC_RC]),
    .xt_rise   (tick_rise[SRC_XT]),
    .halt      (halt),
    .stop      (stop),
    .refresh   (refresh),
    .cfg_we    (cfg_we),
    .wdt_pulse (wdt_rst)
  );

endmodule

// File: tb/wdog_ctrl_test.sv
module wdog_ctrl_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0, rst = 1'b1;
  logic       rc_tick = 1'b0, xt_tick = 1'b0, halt = 1'b0, stop = 1'b0;
  logic       cfg_we = 1'b0, refresh = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       wdt_rst;

  int    cyc = 0, checks = 0, errors = 0;
  int    expq[$];
  string reqq[$];
  bit    prev_rst = 1'b0;
  int    exp_cyc;
  string exp_req;

  localparam int RC_MS [4] = '{5, 10, 20, 80};
  localparam int XT_T  [4] = '{128, 256, 512, 2048};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_ctrl #(.RC_MS_TICKS(1)) uut (
    .clk(clk), .rst(rst), .rc_tick(rc_tick), .xt_tick(xt_tick),
    .halt(halt), .stop(stop), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .refresh(refresh), .wdt_rst(wdt_rst)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected pulse cycle and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (wdt_rst) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4", "unexpected pulse at cycle", cyc, -1);
        end else begin
          exp_cyc = expq.pop_front();
          exp_req = reqq.pop_front();
          check(cyc == exp_cyc, exp_req, "pulse cycle (R5 latency)", cyc, exp_cyc);
        end
        if (prev_rst) check(1'b0, "R4", "pulse width cycles", 2, 1);
      end
      prev_rst <= wdt_rst;
    end
  end

  function automatic logic [7:0] mb(bit xt, bit stop_run, bit halt_run, logic [1:0] tap);
    return {3'b000, xt, stop_run, halt_run, tap};
  endfunction

  // Driver: one tick, held high two cycles (R5: counts once)
  task automatic pulse_tick(bit xt, bit expect_to, string req);
    @(negedge clk);
    if (xt) xt_tick = 1'b1; else rc_tick = 1'b1;
    if (expect_to) begin
      expq.push_back(cyc + 3);
      reqq.push_back(req);
    end
    repeat (2) @(negedge clk);
    xt_tick = 1'b0;
    rc_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(bit xt, int n, bit expect_last, string req);
    for (int i = 0; i < n; i++) pulse_tick(xt, expect_last && (i == n - 1), req);
  endtask

  task automatic drained(string req);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, req, "pending expected pulses", expq.size(), 0);
    expq.delete();
    reqq.delete();
  endtask

  // No pulse one tick early, then exactly on the n-th tick
  task automatic exact(bit xt, int n, string req);
    ticks(xt, n - 1, 1'b0, req);
    drained(req);
    ticks(xt, 1, 1'b1, req);
    drained(req);
  endtask

  task automatic write_mode(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_refresh();
    @(negedge clk);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(wdt_rst == 1'b0, "R1", "wdt_rst in reset", wdt_rst, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(wdt_rst == 1'b0, "R1", "wdt_rst after reset", wdt_rst, 0);

    // R1: default tap 01 on RC = 10 ticks
    exact(1'b0, 10, "R1");
    // R4: periodic restart, a full tap again
    exact(1'b0, 10, "R4");

    // R2: RC taps
    for (int t = 0; t < 4; t++) begin
      write_mode(mb(1'b0, 1'b1, 1'b1, 2'(t)));
      exact(1'b0, RC_MS[t], "R2");
    end

    // R3: crystal taps
    for (int t = 0; t < 4; t++) begin
      write_mode(mb(1'b1, 1'b1, 1'b1, 2'(t)));
      exact(1'b1, XT_T[t], "R3");
    end

    // R11: RC ticks ignored in crystal mode
    write_mode(mb(1'b1, 1'b1, 1'b1, 2'b00));
    ticks(1'b1, 100, 1'b0, "R11");
    ticks(1'b0, 50, 1'b0, "R11");
    exact(1'b1, 28, "R11");

    // R6: freeze during HALT with bit 2 clear
    write_mode(mb(1'b1, 1'b1, 1'b0, 2'b00));
    ticks(1'b1, 100, 1'b0, "R6");
    halt = 1'b1;
    ticks(1'b1, 50, 1'b0, "R6");
    halt = 1'b0;
    exact(1'b1, 28, "R6");
    // R6: bit 2 set keeps counting in HALT
    write_mode(mb(1'b1, 1'b1, 1'b1, 2'b00));
    halt = 1'b1;
    exact(1'b1, 128, "R6");
    halt = 1'b0;

    // R7: freeze during STOP with bit 3 clear
    write_mode(mb(1'b1, 1'b0, 1'b1, 2'b00));
    ticks(1'b1, 100, 1'b0, "R7");
    stop = 1'b1;
    ticks(1'b1, 50, 1'b0, "R7");
    stop = 1'b0;
    exact(1'b1, 28, "R7");
    write_mode(mb(1'b1, 1'b1, 1'b1, 2'b00));
    stop = 1'b1;
    exact(1'b1, 128, "R7");
    stop = 1'b0;

    // R8: refresh clears the count
    ticks(1'b1, 100, 1'b0, "R8");
    do_refresh();
    exact(1'b1, 128, "R8");

    // R9: mode write clears the count
    ticks(1'b1, 100, 1'b0, "R9");
    write_mode(mb(1'b1, 1'b1, 1'b1, 2'b00));
    exact(1'b1, 128, "R9");

    // R10: reserved bits 7:5 set, crystal tap 00 still 128
    write_mode(8'hFC);
    exact(1'b1, 128, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule